// File: doc/BRIEF.md
# Chip-Select Decoder with Online-Spare Redirect

This block takes a normalized DRAM input address and decides which of a set of rank chip-selects answers it. Each table entry has a raw base, a raw mask and an enable. Before comparison, the base and mask are cleaned up by one of two fixed bit fix-ups. A layout-select pin picks which fix-up applies. An entry answers when it is enabled and the address agrees with the cleaned base on every bit the cleaned mask does not cover. When several entries answer, the lowest index wins.

After the match, online sparing is applied. If the matched rank is the one nominated as failed, the result is steered to the designated spare rank. The spare's own table entry plays no part in that swap. If a swap is needed but the spare number is not usable, an error flag is raised and the matched rank is kept.

Addresses enter on a valid/ready stream, and each accepted address produces one registered result on an output valid/ready stream. The rules for back-pressure are as follows:
- An address is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being drained in that cycle.
- A result waiting with `out_ready` low keeps all of its fields frozen.

The configuration and the sparing inputs are plain control pins. They are sampled on the edge that accepts the address.

Top module: `csdec_top`

## Requirements
- R1: An entry responds when its enable bit is 1 and (addr AND NOT mask_eff) equals (base_eff AND NOT mask_eff). `out_hit` is 1 when any entry responds.
- R2: An entry whose enable bit is 0 never responds, whatever its base and mask.
- R3: When no entry responds, `out_none` is 1 and `out_hit`, `out_match`, `out_eff` and `out_spare_err` are all 0. `out_none` is always the inverse of `out_hit`.
- R4: When several entries respond, `out_match` is the lowest responding index.
- R5: With `layout_new`=1, base_eff = base AND 0x1FF83FE0, and mask_eff = (mask OR 0x0007C01F) AND 0x1FFFFFFF.
- R6: With `layout_new`=0, base_eff = base AND 0xFFE0FE00, and mask_eff = (mask OR 0x001F01FF) AND 0x3FFFFFFF.
- R7: A redirect is needed when there is a hit, `bad_valid`=1 and `out_match` equals `bad_num`. If in that case `spare_valid`=1 and `spare_num` < NUM_CS, then `out_eff` = `spare_num`, even when the spare entry is disabled or does not match.
- R8: If `bad_valid`=0, or the matched index differs from `bad_num`, then `out_eff` equals `out_match` and `out_spare_err` is 0.
- R9: If a redirect is needed but `spare_valid`=0 or `spare_num` >= NUM_CS, then `out_spare_err` is 1 and `out_eff` equals `out_match`.
- R10: An address is accepted when `in_valid` and `in_ready` are both high, with `in_ready` = !`out_valid` OR `out_ready`. Its result appears with `out_valid` on the next cycle. While `out_valid`=1 and `out_ready`=0, every output field holds.
- R11: After reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Address can be taken this cycle |
| in_addr | input | 32 | Normalized DRAM input address |
| layout_new | input | 1 | 1 = newer fix-up, 0 = older fix-up |
| cs_base | input | NUM_CS*32 | Raw base per entry |
| cs_mask | input | NUM_CS*32 | Raw mask per entry |
| cs_en | input | NUM_CS | Enable per entry |
| bad_valid | input | 1 | Failed-rank number is valid |
| bad_num | input | RANK_W | Failed-rank number |
| spare_valid | input | 1 | Spare-rank number is valid |
| spare_num | input | RANK_W | Spare-rank number |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Result consumed this cycle |
| out_hit | output | 1 | Some entry responded |
| out_none | output | 1 | No entry responded |
| out_match | output | RANK_W | Lowest responding index |
| out_eff | output | RANK_W | Index after sparing |
| out_spare_err | output | 1 | Redirect needed but spare unusable |

## Verification
Two things can happen in the same cycle: the priority choice among overlapping entries, and the spare redirect. The overlap is provoked by widening entry 0's mask so that both entry 0 and entry 1 answer one address, with the failed rank nominated as 0. The result then has to show the lowest index as the match and the spare as the effective rank. A behavioural model in the bench judges every cycle's output, with random output stalls active throughout.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  localparam int ADDR_W = 32;

  localparam logic [ADDR_W-1:0] NEW_BASE_KEEP = 32'h1FF8_3FE0;
  localparam logic [ADDR_W-1:0] NEW_MASK_SET  = 32'h0007_C01F;
  localparam logic [ADDR_W-1:0] NEW_MASK_KEEP = 32'h1FFF_FFFF;
  localparam logic [ADDR_W-1:0] OLD_BASE_KEEP = 32'hFFE0_FE00;
  localparam logic [ADDR_W-1:0] OLD_MASK_SET  = 32'h001F_01FF;
  localparam logic [ADDR_W-1:0] OLD_MASK_KEEP = 32'h3FFF_FFFF;

  typedef struct packed {
    logic hit;
    logic none;
    logic spare_err;
  } flags_t;
endpackage

// File: rtl/csdec_fixup.sv
module csdec_fixup
  import csdec_pkg::*;
#(
  parameter int NUM_CS = 8
) (
  input  logic                           layout_new,
  input  logic [NUM_CS-1:0][ADDR_W-1:0]  base_raw,
  input  logic [NUM_CS-1:0][ADDR_W-1:0]  mask_raw,
  output logic [NUM_CS-1:0][ADDR_W-1:0]  base_eff,
  output logic [NUM_CS-1:0][ADDR_W-1:0]  mask_eff
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_ent
    always_comb begin
      if (layout_new) begin
        base_eff[g] = base_raw[g] & NEW_BASE_KEEP;
        mask_eff[g] = (mask_raw[g] | NEW_MASK_SET) & NEW_MASK_KEEP;
      end else begin
        base_eff[g] = base_raw[g] & OLD_BASE_KEEP;
        mask_eff[g] = (mask_raw[g] | OLD_MASK_SET) & OLD_MASK_KEEP;
      end
    end
  end
endmodule

// File: rtl/csdec_match.sv
module csdec_match
  import csdec_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int RANK_W = 4
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic [NUM_CS-1:0][ADDR_W-1:0]  base_eff,
  input  logic [NUM_CS-1:0][ADDR_W-1:0]  mask_eff,
  input  logic [NUM_CS-1:0]              en,
  output logic                           hit,
  output logic [RANK_W-1:0]              idx
);
  logic [NUM_CS-1:0] resp;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
    assign resp[g] = en[g] &&
      ((addr & ~mask_eff[g]) == (base_eff[g] & ~mask_eff[g]));
  end

  assign hit = |resp;

  always_comb begin
    idx = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (resp[i]) idx = RANK_W'(i);
    end
  end
endmodule

// File: rtl/csdec_spare.sv
module csdec_spare #(
  parameter int NUM_CS = 8,
  parameter int RANK_W = 4
) (
  input  logic              hit,
  input  logic [RANK_W-1:0] idx,
  input  logic              bad_valid,
  input  logic [RANK_W-1:0] bad_num,
  input  logic              spare_valid,
  input  logic [RANK_W-1:0] spare_num,
  output logic [RANK_W-1:0] eff,
  output logic              err
);
  localparam logic [RANK_W:0] NCS = (RANK_W + 1)'(NUM_CS);

  logic need, usable;

  assign need   = hit && bad_valid && (idx == bad_num);
  assign usable = spare_valid && ({1'b0, spare_num} < NCS);
  assign eff    = (need && usable) ? spare_num : idx;
  assign err    = need && !usable;
endmodule

// File: rtl/csdec_top.sv
module csdec_top
  import csdec_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int RANK_W = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [ADDR_W-1:0]              in_addr,
  input  logic                           layout_new,
  input  logic [NUM_CS-1:0][ADDR_W-1:0]  cs_base,
  input  logic [NUM_CS-1:0][ADDR_W-1:0]  cs_mask,
  input  logic [NUM_CS-1:0]              cs_en,
  input  logic                           bad_valid,
  input  logic [RANK_W-1:0]              bad_num,
  input  logic                           spare_valid,
  input  logic [RANK_W-1:0]              spare_num,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic                           out_hit,
  output logic                           out_none,
  output logic [RANK_W-1:0]              out_match,
  output logic [RANK_W-1:0]              out_eff,
  output logic                           out_spare_err
);
  logic [NUM_CS-1:0][ADDR_W-1:0] base_eff, mask_eff;
  logic                          c_hit, c_err;
  logic [RANK_W-1:0]             c_idx, c_eff;
  flags_t                        flg;
  logic                          take;

  csdec_fixup #(.NUM_CS(NUM_CS)) u_fix (
    .layout_new(layout_new), .base_raw(cs_base), .mask_raw(cs_mask),
    .base_eff(base_eff), .mask_eff(mask_eff)
  );

  csdec_match #(.NUM_CS(NUM_CS), .RANK_W(RANK_W)) u_match (
    .addr(in_addr), .base_eff(base_eff), .mask_eff(mask_eff), .en(cs_en),
    .hit(c_hit), .idx(c_idx)
  );

  csdec_spare #(.NUM_CS(NUM_CS), .RANK_W(RANK_W)) u_spare (
    .hit(c_hit), .idx(c_idx), .bad_valid(bad_valid), .bad_num(bad_num),
    .spare_valid(spare_valid), .spare_num(spare_num), .eff(c_eff), .err(c_err)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      flg       <= '0;
      out_match <= '0;
      out_eff   <= '0;
    end else begin
      if (take) begin
        out_valid     <= 1'b1;
        flg.hit       <= c_hit;
        flg.none      <= !c_hit;
        flg.spare_err <= c_err;
        out_match     <= c_idx;
        out_eff       <= c_eff;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_hit       = flg.hit;
  assign out_none      = flg.none;
  assign out_spare_err = flg.spare_err;

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_hit) && $stable(out_match)
      && $stable(out_eff) && $stable(out_spare_err)); // R10

  AST_HIT_XOR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hit != out_none)); // R3

  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_none |-> out_match == '0 && out_eff == '0 && !out_spare_err); // R3

  AST_ERR_KEEPS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_spare_err |-> out_hit && out_eff == out_match); // R9

  AST_REDIRECT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_eff != out_match) |-> out_hit && !out_spare_err); // R7

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R10
endmodule

// File: tb/csdec_top_test.sv
module csdec_top_test;
  localparam int NCS = 8;
  localparam int RW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_addr = '0;
  logic layout_new = 1'b1;
  logic [NCS-1:0][31:0] cs_base = '0;
  logic [NCS-1:0][31:0] cs_mask = '0;
  logic [NCS-1:0] cs_en = '0;
  logic bad_valid = 1'b0;
  logic [RW-1:0] bad_num = '0;
  logic spare_valid = 1'b0;
  logic [RW-1:0] spare_num = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_hit, out_none, out_spare_err;
  logic [RW-1:0] out_match, out_eff;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit stall_en = 1'b0;
  string tag = "R11";

  bit    qh[$];
  int    qm[$];
  int    qe[$];
  bit    qer[$];
  string qt[$];

  always #4 clk = ~clk;

  csdec_top #(.NUM_CS(NCS), .RANK_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .layout_new(layout_new), .cs_base(cs_base),
    .cs_mask(cs_mask), .cs_en(cs_en), .bad_valid(bad_valid),
    .bad_num(bad_num), .spare_valid(spare_valid), .spare_num(spare_num),
    .out_valid(out_valid), .out_ready(out_ready), .out_hit(out_hit),
    .out_none(out_none), .out_match(out_match), .out_eff(out_eff),
    .out_spare_err(out_spare_err)
  );

  function automatic void ref_eval(input logic [31:0] a, output bit h,
                                   output int m, output int e, output bit er);
    logic [31:0] b, mk;
    bit need, ok;
    h = 0; m = 0;
    for (int i = 0; i < NCS; i++) begin
      if (layout_new) begin
        b  = cs_base[i] & 32'h1FF83FE0;
        mk = (cs_mask[i] | 32'h0007C01F) & 32'h1FFFFFFF;
      end else begin
        b  = cs_base[i] & 32'hFFE0FE00;
        mk = (cs_mask[i] | 32'h001F01FF) & 32'h3FFFFFFF;
      end
      if (!h && cs_en[i] && ((a & ~mk) == (b & ~mk))) begin
        h = 1; m = i;
      end
    end
    need = h && bad_valid && (m == int'(bad_num));
    ok   = spare_valid && (int'(spare_num) < NCS);
    e    = (need && ok) ? int'(spare_num) : m;
    er   = need && !ok;
  endfunction

  task automatic chk(input bit cond, input string what, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s (%s) actual=%0d expected=%0d at cycle %0d", what, tag, act, exp, cycles);
    end
  endtask

  // Model: pop on drain, push on accept
  always @(posedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready && qh.size() > 0) begin
        void'(qh.pop_front()); void'(qm.pop_front()); void'(qe.pop_front());
        void'(qer.pop_front()); void'(qt.pop_front());
      end
      if (in_valid && in_ready) begin
        bit h, er; int m, e;
        ref_eval(in_addr, h, m, e, er);
        qh.push_back(h); qm.push_back(m); qe.push_back(e);
        qer.push_back(er); qt.push_back(tag);
      end
      out_ready <= stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(out_valid == (qh.size() > 0), "R10 out_valid", int'(out_valid), int'(qh.size() > 0));
      if (out_valid && qh.size() > 0) begin
        chk(out_hit == qh[0], {"R1 hit/", qt[0]}, int'(out_hit), int'(qh[0]));
        chk(out_none == !qh[0], {"R3 none/", qt[0]}, int'(out_none), int'(!qh[0]));
        chk(int'(out_match) == qm[0], {"R4 match/", qt[0]}, int'(out_match), qm[0]);
        chk(int'(out_eff) == qe[0], {"R7 eff/", qt[0]}, int'(out_eff), qe[0]);
        chk(out_spare_err == qer[0], {"R9 err/", qt[0]}, int'(out_spare_err), int'(qer[0]));
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send(input logic [31:0] a);
    @(negedge clk);
    in_addr  = a;
    in_valid = 1'b1;
    #1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic grid_new();
    layout_new = 1'b1;
    for (int i = 0; i < NCS; i++) begin
      cs_base[i] = 32'(i) << 19;
      cs_mask[i] = '0;
    end
    cs_en = '1;
  endtask

  task automatic grid_old();
    layout_new = 1'b0;
    for (int i = 0; i < NCS; i++) begin
      cs_base[i] = 32'(i) << 21;
      cs_mask[i] = '0;
    end
    cs_en = '1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: nothing valid out of reset
    chk(out_valid == 1'b0, "R11 reset out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 idle after reset", int'(out_valid), 0);

    // R5, R1: newer layout, forced don't-care bits [18:14] and [4:0]
    tag = "R5";
    grid_new();
    for (int i = 0; i < NCS; i++)
      send((32'(i) << 19) | (32'($urandom_range(0, 31)) << 14) | 32'($urandom_range(0, 31)));
    send(32'h0000_0100);           // bit 8 compared -> none (R3)
    send((32'd2 << 19) | 32'h4000_0000); // upper bit compared -> none

    // R2: disabled entry never answers
    tag = "R2";
    cs_en[3] = 1'b0;
    send(32'd3 << 19);
    cs_mask[3] = 32'hFFFF_FFFF;
    send(32'd3 << 19);
    cs_en = '1; cs_mask[3] = '0;

    // R4: overlap, lowest index wins
    tag = "R4";
    cs_mask[0] = 32'h0008_0000;
    send(32'd1 << 19);
    cs_mask[0] = '0;

    // R6: older layout
    tag = "R6";
    grid_old();
    for (int i = 0; i < NCS; i++)
      send((32'(i) << 21) | (32'($urandom_range(0, 31)) << 16) | 32'($urandom_range(0, 511)));
    send(32'h0000_0200);
    send(32'h8000_0000);

    // R7: redirect to spare, spare entry disabled
    tag = "R7";
    grid_new();
    stall_en = 1'b1;
    bad_valid = 1; bad_num = 2; spare_valid = 1; spare_num = 6;
    cs_en[6] = 1'b0;
    send(32'd2 << 19);
    send(32'd6 << 19);
    // priority and redirect in the same cycle
    cs_mask[0] = 32'h0008_0000; bad_num = 0;
    send(32'd1 << 19);
    cs_mask[0] = '0; cs_en = '1;

    // R8: no redirect cases
    tag = "R8";
    bad_num = 2;
    send(32'd3 << 19);
    bad_valid = 0; spare_valid = 0;
    send(32'd2 << 19);
    bad_valid = 0; spare_valid = 1;
    send(32'd2 << 19);

    // R9: spare unusable
    tag = "R9";
    bad_valid = 1; bad_num = 5; spare_valid = 1; spare_num = 9;
    send(32'd5 << 19);
    spare_valid = 0; spare_num = 1;
    send(32'd5 << 19);

    // R10: random mix under back-pressure
    tag = "R10";
    for (int n = 0; n < 300; n++) begin
      layout_new  = 1'($urandom_range(0, 1));
      for (int i = 0; i < NCS; i++) begin
        cs_base[i] = layout_new ? (32'($urandom_range(0, 7)) << 19) : (32'($urandom_range(0, 7)) << 21);
        cs_mask[i] = ($urandom_range(0, 3) == 0) ? 32'h0030_0000 : 32'h0;
      end
      cs_en       = NCS'($urandom);
      bad_valid   = 1'($urandom_range(0, 1));
      bad_num     = RW'($urandom_range(0, 7));
      spare_valid = 1'($urandom_range(0, 1));
      spare_num   = RW'($urandom_range(0, 10));
      send(layout_new ? (32'($urandom_range(0, 7)) << 19) : (32'($urandom_range(0, 7)) << 21));
    end

    stall_en = 1'b0;
    while (qh.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule